// File: doc/BRIEF.md
# SPI Host Byte Engine

This block is the serial core of an SPI controller that only ever acts as host. A one-cycle start command carries a byte count. The engine then moves that many bytes, one at a time. It takes each outgoing byte from the read side of a transmit FIFO and hands each received byte to the write side of a receive FIFO. The FIFOs, chip select and any register interface sit outside the block.

The serial clock is derived from the system clock through a programmable half-period divider. All four polarity/phase combinations are supported, and each byte can be sent with either its most or its least significant bit first. The engine never clocks a byte it cannot complete. Before each byte it waits, with the serial clock parked at its idle level, until an outgoing byte is present and the receive side has room. Software may therefore issue a start before any data is queued.

Top module: `spi_byte_engine`

## Requirements
- R1: While a byte is being clocked, each serial-clock half period lasts exactly `cfg_half_i`+1 system cycles, and a byte takes 16 half periods.
- R2: Whenever the engine is not clocking a byte, `sclk_o` rests at the polarity setting, which is 0 for idle-low and 1 for idle-high.
- R3: With phase 0, the first half of each bit sits at the idle level and the second half at the opposite level. Each bit is valid on `sdo_o` from the first cycle of its first half.
- R4: With phase 1, `sclk_o` leaves the idle level at the very start of each bit and returns to it at mid-bit. `sdi_i` is captured at that mid-bit return.
- R5: In both phases, `sdi_i` is captured in the last system cycle of each bit's first half. `sdo_o` changes only at bit boundaries. With `cfg_msb_first_i`=1, bit 7 is sent and received first; with 0, bit 0 is first.
- R6: A start carries an 11-bit count, and exactly that many bytes are transferred (up to 2047). A start raised while `idle_o` is low has no effect.
- R7: A start with count 0 raises `done_o` in the following cycle without any `sclk_o` toggle.
- R8: Before each byte, the engine waits with `sclk_o` idle while transmit is enabled and `tx_valid_i` is low, or while receive is enabled and `rx_space_i` is low.
- R9: With transmit disabled, `tx_pop_o` never rises. With receive disabled, `rx_push_o` never rises and received bits are dropped.
- R10: `tx_pop_o` pulses in the cycle the byte in `tx_data_i` is taken, at the start of each byte. `rx_push_o` pulses in the final system cycle of a byte, with the complete byte on `rx_data_o`.
- R11: `idle_o` is high exactly when no transfer is pending. `done_o` is a one-cycle pulse, raised in the first idle cycle after the last byte.
- R12: Polarity, phase, bit order, divider and both enables are taken at the start cycle and held until the transfer ends. Input changes in the meantime have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start command pulse |
| start_count_i | input | 11 | Number of bytes for the transfer |
| cfg_cpol_i | input | 1 | Serial clock idle level |
| cfg_cpha_i | input | 1 | Clock phase select |
| cfg_msb_first_i | input | 1 | 1: MSB first, 0: LSB first |
| cfg_half_i | input | 16 | Half period length minus one, in system cycles |
| tx_en_i | input | 1 | Send bytes from the transmit FIFO |
| rx_en_i | input | 1 | Store received bytes |
| tx_valid_i | input | 1 | Transmit FIFO holds a byte |
| tx_data_i | input | 8 | Head byte of the transmit FIFO |
| tx_pop_o | output | 1 | Take the head byte |
| rx_space_i | input | 1 | Receive FIFO has room for a byte |
| rx_push_o | output | 1 | Write `rx_data_o` to the receive FIFO |
| rx_data_o | output | 8 | Received byte |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data to the device |
| sdi_i | input | 1 | Serial data from the device |
| idle_o | output | 1 | No transfer pending |
| done_o | output | 1 | Transfer completed pulse |

## Verification
The bench drives the four clock modes with several divider values and both bit orders. It aims at the cases a careless engine gets wrong. A divider that miscounts its terminal value stretches or shrinks every half period, and a phase mix-up samples one half too early. A stall test starts transfers with an empty transmit FIFO and a full receive FIFO; an engine that does not check readiness per byte would toggle the clock and send stale data. Further tests cover a zero count, a start issued while busy, and settings changed during a transfer; a wrong engine here would hang, restart mid-transfer, or change the clock shape partway. A 1025-byte run catches a count truncated to ten bits.

// File: rtl/spi_eng_pkg.sv
`timescale 1ns/1ps
package spi_eng_pkg;

    localparam int FRAME_W = 8;
    localparam int CNT_W   = 11;
    localparam int DIV_W   = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SHIFT = 2'd2
    } eng_state_e;

    // Transfer-wide settings frozen for the length of a transfer
    typedef struct packed {
        logic pol;
        logic pha;
        logic msb_first;
        logic send_en;
        logic recv_en;
    } eng_mode_t;

    localparam eng_mode_t MODE_RESET = '{pol: 1'b0, pha: 1'b0, msb_first: 1'b1,
                                         send_en: 1'b0, recv_en: 1'b0};

    // Serial clock level within a byte, given whether the half is the second of its bit
    function automatic logic clk_level(input logic pol, input logic pha, input logic second_half);
        return pol ^ (pha ? ~second_half : second_half);
    endfunction

endpackage

// File: rtl/spi_eng_halfcnt.sv
`timescale 1ns/1ps
module spi_eng_halfcnt #(
    parameter int DIV_W = spi_eng_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [DIV_W-1:0] limit_i,
    output logic             wrap_o
);
    logic [DIV_W-1:0] cnt_q;
    logic             at_limit;

    assign at_limit = (cnt_q == limit_i);
    assign wrap_o   = run_i && at_limit;

    always_ff @(posedge clk) begin
        if (rst || !run_i || at_limit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi_eng_shifter.sv
`timescale 1ns/1ps
module spi_eng_shifter #(
    parameter int FRAME_W = spi_eng_pkg::FRAME_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] load_data_i,
    input  logic               shift_i,
    input  logic               sample_i,
    input  logic               msb_first_i,
    input  logic               sdi_i,
    output logic               tx_bit_o,
    output logic [FRAME_W-1:0] rx_byte_o
);
    logic [FRAME_W-1:0] tx_q;
    logic [FRAME_W-1:0] rx_q;

    assign tx_bit_o  = msb_first_i ? tx_q[FRAME_W-1] : tx_q[0];
    assign rx_byte_o = rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
        end else if (load_i) begin
            tx_q <= load_data_i;
        end else if (shift_i) begin
            tx_q <= msb_first_i ? {tx_q[FRAME_W-2:0], 1'b0} : {1'b0, tx_q[FRAME_W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q <= '0;
        end else if (sample_i) begin
            rx_q <= msb_first_i ? {rx_q[FRAME_W-2:0], sdi_i} : {sdi_i, rx_q[FRAME_W-1:1]};
        end
    end
endmodule

// File: rtl/spi_byte_engine.sv
`timescale 1ns/1ps
module spi_byte_engine
    import spi_eng_pkg::*;
#(
    parameter int FRAME_W = spi_eng_pkg::FRAME_W,
    parameter int CNT_W   = spi_eng_pkg::CNT_W,
    parameter int DIV_W   = spi_eng_pkg::DIV_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [CNT_W-1:0]   start_count_i,
    input  logic               cfg_cpol_i,
    input  logic               cfg_cpha_i,
    input  logic               cfg_msb_first_i,
    input  logic [DIV_W-1:0]   cfg_half_i,
    input  logic               tx_en_i,
    input  logic               rx_en_i,
    input  logic               tx_valid_i,
    input  logic [FRAME_W-1:0] tx_data_i,
    output logic               tx_pop_o,
    input  logic               rx_space_i,
    output logic               rx_push_o,
    output logic [FRAME_W-1:0] rx_data_o,
    output logic               sclk_o,
    output logic               sdo_o,
    input  logic               sdi_i,
    output logic               idle_o,
    output logic               done_o
);
    localparam int HALVES = 2 * FRAME_W;
    localparam int PH_W   = $clog2(HALVES);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALVES - 1);

    eng_state_e       state_q;
    eng_mode_t        mode_q;
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] left_q;
    logic [PH_W-1:0]  ph_q;
    logic             done_q;

    logic shifting, wrap, ready, load, byte_end, sample, shift, tx_bit;

    assign shifting = (state_q == ST_SHIFT);
    assign ready    = (!mode_q.send_en || tx_valid_i) && (!mode_q.recv_en || rx_space_i);
    assign load     = (state_q == ST_WAIT) && ready;
    assign sample   = wrap && !ph_q[0];
    assign shift    = wrap && ph_q[0];
    assign byte_end = wrap && (ph_q == PH_LAST);

    spi_eng_halfcnt #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .run_i   (shifting),
        .limit_i (div_q),
        .wrap_o  (wrap)
    );

    spi_eng_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load),
        .load_data_i (mode_q.send_en ? tx_data_i : '0),
        .shift_i     (shift),
        .sample_i    (sample),
        .msb_first_i (mode_q.msb_first),
        .sdi_i       (sdi_i),
        .tx_bit_o    (tx_bit),
        .rx_byte_o   (rx_data_o)
    );

    assign tx_pop_o  = load && mode_q.send_en;
    assign rx_push_o = byte_end && mode_q.recv_en;
    assign sclk_o    = shifting ? clk_level(mode_q.pol, mode_q.pha, ph_q[0]) : mode_q.pol;
    assign sdo_o     = shifting && mode_q.send_en && tx_bit;
    assign idle_o    = (state_q == ST_IDLE);
    assign done_o    = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_RESET;
            div_q   <= '0;
            left_q  <= '0;
            ph_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    mode_q <= '{pol: cfg_cpol_i, pha: cfg_cpha_i, msb_first: cfg_msb_first_i,
                                send_en: tx_en_i, recv_en: rx_en_i};
                    div_q  <= cfg_half_i;
                    if (start_i) begin
                        if (start_count_i == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            left_q  <= start_count_i;
                            state_q <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (ready) begin
                        ph_q    <= '0;
                        state_q <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (byte_end) begin
                        left_q <= left_q - 1'b1;
                        if (left_q == CNT_W'(1)) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            state_q <= ST_WAIT;
                        end
                    end else if (wrap) begin
                        ph_q <= ph_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_eng_chk.sv
`timescale 1ns/1ps
module spi_eng_chk (
    input logic clk,
    input logic rst,
    input logic cfg_cpol_i,
    input logic idle_o,
    input logic sclk_o,
    input logic done_o,
    input logic tx_pop_o,
    input logic tx_valid_i,
    input logic rx_push_o
);
    // R2
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        (idle_o && $past(idle_o) && !$past(rst)) |-> (sclk_o == $past(cfg_cpol_i)));

    // R10
    pop_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
        tx_pop_o |-> tx_valid_i);

    // R10
    pop_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tx_pop_o |=> !tx_pop_o);

    // R11
    done_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> idle_o);

    // R10
    pop_push_apart_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tx_pop_o, rx_push_o}));
endmodule

bind spi_byte_engine spi_eng_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_cpol_i (cfg_cpol_i),
    .idle_o     (idle_o),
    .sclk_o     (sclk_o),
    .done_o     (done_o),
    .tx_pop_o   (tx_pop_o),
    .tx_valid_i (tx_valid_i),
    .rx_push_o  (rx_push_o)
);

// File: tb/sim_spi_byte_engine.sv
`timescale 1ns/1ps
module sim_spi_byte_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [10:0] start_count_i = '0;
    logic        cfg_cpol_i = 1'b0, cfg_cpha_i = 1'b0, cfg_msb_first_i = 1'b1;
    logic [15:0] cfg_half_i = '0;
    logic        tx_en_i = 1'b0, rx_en_i = 1'b0;
    logic        tx_valid_i = 1'b0, rx_space_i = 1'b1, sdi_i = 1'b0;
    logic [7:0]  tx_data_i = '0;
    logic        tx_pop_o, rx_push_o, sclk_o, sdo_o, idle_o, done_o;
    logic [7:0]  rx_data_o;

    always #2.5 clk = ~clk;

    spi_byte_engine u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .start_count_i(start_count_i),
        .cfg_cpol_i(cfg_cpol_i), .cfg_cpha_i(cfg_cpha_i), .cfg_msb_first_i(cfg_msb_first_i),
        .cfg_half_i(cfg_half_i), .tx_en_i(tx_en_i), .rx_en_i(rx_en_i),
        .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i), .tx_pop_o(tx_pop_o),
        .rx_space_i(rx_space_i), .rx_push_o(rx_push_o), .rx_data_o(rx_data_o),
        .sclk_o(sclk_o), .sdo_o(sdo_o), .sdi_i(sdi_i), .idle_o(idle_o), .done_o(done_o)
    );

    int checks = 0, errors = 0, cycles = 0;
    string scen = "reset";

    // environment
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];
    int rx_cap = 64;
    logic [15:0] lfsr = 16'hACE1;
    bit last_pop = 0, last_push = 0;
    logic [7:0] last_rx = '0;

    // behavioural reference
    bit m_busy = 0, m_wait = 0, m_done = 0;
    bit m_cpol = 0, m_cpha = 0, m_msb = 1, m_txen = 0, m_rxen = 0;
    int m_H = 1, m_cyc = 0, m_left = 0;
    logic [7:0] m_tx = '0, m_rx = '0;

    // observation counters
    int edges = 0, pops = 0, pushes = 0, dones = 0;
    logic prev_sclk = 1'b0;

    task automatic chk(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s", msg);
        end
    endtask

    function automatic bit m_ready();
        return (!m_txen || tx_q.size() > 0) && (!m_rxen || rx_q.size() < rx_cap);
    endfunction

    task automatic tick();
        bit run;
        int k;
        logic e_sclk, e_sdo;
        bit e_pop, e_push;
        @(negedge clk);
        cycles++;
        if (cycles > 190000) begin
            errors++;
            $display("FAIL watchdog expired (%s) got running exp finished", scen);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
        if (last_pop) void'(tx_q.pop_front());
        if (last_push) rx_q.push_back(last_rx);
        tx_valid_i = tx_q.size() > 0;
        tx_data_i  = (tx_q.size() > 0) ? tx_q[0] : 8'h00;
        rx_space_i = rx_q.size() < rx_cap;
        lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        sdi_i = lfsr[0];
        #1;
        run = m_busy && !m_wait;
        k = m_cyc / m_H;
        e_sclk = run ? (m_cpol ^ (m_cpha ? ((k % 2) == 0) : ((k % 2) == 1))) : m_cpol;
        e_sdo  = m_msb ? m_tx[7 - k / 2] : m_tx[k / 2];
        e_pop  = m_busy && m_wait && m_ready() && m_txen;
        e_push = run && (m_cyc == 16 * m_H - 1) && m_rxen;
        if (!rst) begin
            chk(sclk_o === e_sclk, $sformatf("R1 sclk (%s) got %b exp %b", scen, sclk_o, e_sclk));
            if (run && m_txen)
                chk(sdo_o === e_sdo, $sformatf("R5 sdo (%s) got %b exp %b", scen, sdo_o, e_sdo));
            chk(tx_pop_o === e_pop, $sformatf("R10 pop (%s) got %b exp %b", scen, tx_pop_o, e_pop));
            chk(rx_push_o === e_push, $sformatf("R10 push (%s) got %b exp %b", scen, rx_push_o, e_push));
            if (e_push)
                chk(rx_data_o === m_rx, $sformatf("R5 rx byte (%s) got %h exp %h", scen, rx_data_o, m_rx));
            chk(idle_o === !m_busy, $sformatf("R11 idle (%s) got %b exp %b", scen, idle_o, !m_busy));
            chk(done_o === m_done, $sformatf("R11 done (%s) got %b exp %b", scen, done_o, m_done));
            if (sclk_o !== prev_sclk) edges++;
            if (tx_pop_o) pops++;
            if (rx_push_o) pushes++;
            if (done_o) dones++;
        end
        prev_sclk = sclk_o;
        last_pop = e_pop;
        last_push = e_push;
        last_rx = m_rx;
        @(posedge clk);
        m_done = 0;
        if (rst) begin
            m_busy = 0; m_cpol = 0; m_cpha = 0; m_msb = 1; m_txen = 0; m_rxen = 0; m_H = 1;
        end else if (!m_busy) begin
            m_cpol = cfg_cpol_i; m_cpha = cfg_cpha_i; m_msb = cfg_msb_first_i;
            m_txen = tx_en_i; m_rxen = rx_en_i; m_H = int'(cfg_half_i) + 1;
            if (start_i) begin
                if (start_count_i == 0) m_done = 1;
                else begin
                    m_busy = 1; m_wait = 1; m_left = int'(start_count_i);
                end
            end
        end else if (m_wait) begin
            if (m_ready()) begin
                m_wait = 0; m_cyc = 0;
                m_tx = m_txen ? tx_data_i : 8'h00;
            end
        end else begin
            k = m_cyc / m_H;
            if ((m_cyc % m_H) == m_H - 1 && (k % 2) == 0) begin
                if (m_msb) m_rx[7 - k / 2] = sdi_i;
                else       m_rx[k / 2] = sdi_i;
            end
            if (m_cyc == 16 * m_H - 1) begin
                m_left--;
                if (m_left == 0) begin m_busy = 0; m_done = 1; end
                else m_wait = 1;
            end else m_cyc++;
        end
        #1;
    endtask

    task automatic setup(input bit pol, input bit pha, input bit msb, input int half,
                         input bit txe, input bit rxe);
        cfg_cpol_i = pol; cfg_cpha_i = pha; cfg_msb_first_i = msb;
        cfg_half_i = 16'(half); tx_en_i = txe; rx_en_i = rxe;
        tick(); tick();
        edges = 0; pops = 0; pushes = 0; dones = 0;
    endtask

    task automatic kick(input int n);
        start_i = 1; start_count_i = 11'(n);
        tick();
        start_i = 0;
    endtask

    task automatic finish_xfer();
        for (int g = 0; g < 40000 && dones == 0; g++) tick();
        chk(dones == 1, $sformatf("R11 one completion (%s) got %0d exp 1", scen, dones));
    endtask

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        chk(idle_o === 1'b1 && sclk_o === 1'b0 && done_o === 1'b0,
            $sformatf("R11 R2 reset state got idle=%b sclk=%b done=%b exp 1 0 0", idle_o, sclk_o, done_o));

        scen = "R3 R5 mode0 msb";
        setup(0, 0, 1, 0, 1, 1);
        tx_q = '{8'hA5, 8'h3C, 8'hF0};
        kick(3); finish_xfer();
        chk(pushes == 3 && pops == 3, $sformatf("R10 byte moves (%s) got %0d/%0d exp 3/3", scen, pops, pushes));
        chk(edges == 48, $sformatf("R1 toggles (%s) got %0d exp 48", scen, edges));
        rx_q.delete();

        scen = "R4 R5 mode1 lsb";
        setup(0, 1, 0, 2, 1, 1);
        tx_q = '{8'h81, 8'h5E};
        kick(2); finish_xfer();
        rx_q.delete();

        scen = "R2 R3 mode2";
        setup(1, 0, 1, 1, 1, 1);
        tx_q = '{8'h12, 8'hEF};
        kick(2); finish_xfer();
        chk(sclk_o === 1'b1, $sformatf("R2 idle high (%s) got %b exp 1", scen, sclk_o));
        rx_q.delete();

        scen = "R4 R1 mode3";
        setup(1, 1, 0, 3, 1, 1);
        tx_q = '{8'h77};
        kick(1); finish_xfer();
        chk(edges == 16, $sformatf("R1 toggles (%s) got %0d exp 16", scen, edges));
        rx_q.delete();

        scen = "R7 zero count";
        setup(0, 0, 1, 0, 1, 1);
        kick(0); tick();
        chk(dones == 1 && edges == 0, $sformatf("R7 (%s) got done=%0d toggles=%0d exp 1 0", scen, dones, edges));

        scen = "R8 tx stall";
        setup(0, 1, 1, 1, 1, 1);
        kick(2);
        repeat (40) tick();
        chk(edges == 0 && idle_o === 1'b0, $sformatf("R8 (%s) got toggles=%0d idle=%b exp 0 0", scen, edges, idle_o));
        tx_q.push_back(8'hC3);
        repeat (60) tick();
        tx_q.push_back(8'h2D);
        finish_xfer();
        rx_q.delete();

        scen = "R8 rx stall";
        setup(0, 0, 1, 0, 0, 1);
        rx_cap = 1; rx_q.push_back(8'h00);
        kick(1);
        repeat (30) tick();
        chk(edges == 0, $sformatf("R8 (%s) got toggles=%0d exp 0", scen, edges));
        rx_q.delete();
        finish_xfer();
        chk(pushes == 1, $sformatf("R8 (%s) got pushes=%0d exp 1", scen, pushes));
        rx_cap = 64; rx_q.delete();

        scen = "R9 tx off";
        setup(1, 0, 0, 0, 0, 1);
        tx_q = '{8'hFF};
        kick(2); finish_xfer();
        chk(pops == 0 && pushes == 2, $sformatf("R9 (%s) got pops=%0d pushes=%0d exp 0 2", scen, pops, pushes));
        tx_q.delete(); rx_q.delete();

        scen = "R9 rx off";
        setup(0, 1, 1, 0, 1, 0);
        tx_q = '{8'h96, 8'h69};
        kick(2); finish_xfer();
        chk(pops == 2 && pushes == 0 && rx_q.size() == 0,
            $sformatf("R9 (%s) got pops=%0d pushes=%0d exp 2 0", scen, pops, pushes));

        scen = "R6 R12 busy start and cfg change";
        setup(0, 0, 1, 1, 1, 1);
        tx_q = '{8'hB4, 8'h4B};
        kick(2);
        repeat (10) tick();
        cfg_cpol_i = 1; cfg_cpha_i = 1; cfg_msb_first_i = 0; cfg_half_i = 16'd5;
        start_i = 1; start_count_i = 11'd7;
        tick();
        start_i = 0;
        repeat (5) tick();
        cfg_cpol_i = 0; cfg_cpha_i = 0; cfg_msb_first_i = 1; cfg_half_i = 16'd1;
        finish_xfer();
        chk(pops == 2 && edges == 32, $sformatf("R6 R12 (%s) got pops=%0d toggles=%0d exp 2 32", scen, pops, edges));
        rx_q.delete();

        scen = "R6 long count";
        setup(0, 0, 1, 0, 0, 0);
        kick(1025); finish_xfer();
        chk(edges == 1025 * 16, $sformatf("R6 (%s) got toggles=%0d exp %0d", scen, edges, 1025 * 16));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule